// File: doc/BRIEF.md
# Shift and Normalize Arithmetic Unit

A register-mapped unit that shifts or normalizes a 32-bit value held in four byte-wide data registers. Software loads the four data bytes over a small byte bus, then writes an 8-bit control register. Every control write starts an operation. A nonzero 5-bit count asks for a shift of that many positions, to the left or to the right. A zero count asks for normalization: the value moves left until its top bit is set, and the count field then reports how many positions it moved.

The shifter moves one bit position per clock and raises a busy output while it works. Two sticky flags sit in the control register. The retrigger error flag catches a data-register write made before the current operation has been closed. An operation is closed by reading the most significant data byte. The overflow flag latches a status pulse from a neighbouring multiply/divide datapath. Both flags clear when the control register is read.

Top module: `shnorm_unit`

## Requirements
- R1: Address map: addresses 0 to 3 are the data bytes, with address 0 holding bits 7:0 and address 3 holding bits 31:24. Address 4 is the control register, laid out as {bit7 error, bit6 overflow, bit5 direction, bits4:0 count}. Other addresses read 0. Bits 7:6 of a control write are ignored.
- R2: Every control write starts an operation, and busy_o is 1 in the cycle after the write edge.
- R3: A nonzero count N shifts the value by exactly N positions, one per clock, with busy_o high for N cycles. Direction 1 shifts right and fills with zeros. Direction 0 shifts left. Bits shifted out are lost. The count field keeps N.
- R4: A zero count normalizes. The value moves left one bit per clock until bit 31 is 1 or 31 shifts are done. The count field then holds the number of shifts s, busy_o stays high for s+1 cycles, and the direction bit has no effect.
- R5: Normalizing a zero value ends after 31 shifts with data 0, count 31 and no flag set.
- R6: Data-register writes while busy_o is 1 leave the data unchanged.
- R7: A data-register write made after a control write and before the next read of address 3 sets the error flag.
- R8: A read of address 3 closes the operation, so later data writes do not set the error flag.
- R9: A read of the control register returns the error flag and then clears it.
- R10: A high ovf_flag_i sets the sticky overflow flag, and a control read clears it. If ovf_flag_i is high in the same cycle as a control read, the flag stays set.
- R11: A control write while busy_o is 1 restarts the operation on the partly shifted value, using the new count and direction.
- R12: After reset, busy_o is 0, the data bytes read 0 and the control register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (side effects only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| ovf_flag_i | input | 1 | Overflow status from the multiply/divide path |
| busy_o | output | 1 | Operation in progress |

## Verification
A shift of N positions keeps busy_o high for exactly N cycles after the write edge. A normalize that takes s shifts keeps it high for s+1 cycles. The bench drives the bus on falling edges, counts busy cycles at each falling edge from the one after the control write, and reads the result only after busy_o has dropped. Flag updates from a strobe appear one edge later, so each flag is checked by a read on the following cycle. Read data is combinational and is sampled shortly after the read address is applied, before the edge that carries the read's clear side effect.

// File: rtl/shnorm_pkg.sv
package shnorm_pkg;
  typedef enum logic {
    OP_SHIFT = 1'b0,
    OP_NORM  = 1'b1
  } op_mode_e;
endpackage

// File: rtl/shnorm_datapath.sv
module shnorm_datapath #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = DATA_W / BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BYTES-1:0] byte_we_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  input  logic                 step_en_i,
  input  logic                 step_right_i,
  output logic [DATA_W-1:0]    data_o,
  output logic                 msb_o
);
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (step_en_i) begin
      data_d = step_right_i ? (data_q >> 1) : (data_q << 1);
    end else begin
      for (int b = 0; b < NUM_BYTES; b++) begin
        if (byte_we_i[b]) data_d[b*BYTE_W +: BYTE_W] = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign data_o = data_q;
  assign msb_o  = data_q[DATA_W-1];

  // R6: data only changes through a step or a byte write
  a_r6_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_en_i && byte_we_i == '0) |=> $stable(data_q))
    else $error("a_r6_data_hold");

  // R3: right shift fills with zero
  a_r3_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && step_right_i) |=> !data_q[DATA_W-1])
    else $error("a_r3_zero_fill");
endmodule

// File: rtl/shnorm_seq.sv
module shnorm_seq
  import shnorm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_dir_i,
  input  logic [CNT_W-1:0] start_cnt_i,
  input  logic             msb_i,
  output logic             busy_o,
  output logic             step_en_o,
  output logic             step_right_o,
  output logic             dir_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] NORM_LIMIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  op_mode_e         mode_q;
  logic             busy_q, dir_q;
  logic [CNT_W-1:0] cnt_q, rem_q;

  // a restart overrides the step of the same cycle
  always_comb begin
    step_en_o    = 1'b0;
    step_right_o = 1'b0;
    if (busy_q && !start_i) begin
      if (mode_q == OP_SHIFT) begin
        step_en_o    = 1'b1;
        step_right_o = dir_q;
      end else if (!msb_i && cnt_q != NORM_LIMIT) begin
        step_en_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mode_q <= OP_SHIFT;
      dir_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      mode_q <= (start_cnt_i == '0) ? OP_NORM : OP_SHIFT;
      dir_q  <= start_dir_i;
      cnt_q  <= start_cnt_i;
      rem_q  <= start_cnt_i;
    end else if (busy_q) begin
      if (mode_q == OP_SHIFT) begin
        rem_q <= rem_q - CNT_ONE;
        if (rem_q == CNT_ONE) busy_q <= 1'b0;
      end else if (step_en_o) begin
        cnt_q <= cnt_q + CNT_ONE;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign dir_o  = dir_q;
  assign cnt_o  = cnt_q;

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o)
    else $error("a_r2_busy_after_start");

  a_r3_shift_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && mode_q == OP_SHIFT && rem_q == CNT_ONE && !start_i) |=> !busy_o)
    else $error("a_r3_shift_ends");

  a_r3_count_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && mode_q == OP_SHIFT && !start_i) |=> $stable(cnt_o))
    else $error("a_r3_count_kept");

  a_r4_norm_msb_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && mode_q == OP_NORM && msb_i && !start_i) |=> (!busy_o && $stable(cnt_o)))
    else $error("a_r4_norm_msb_stop");

  // R5: the limit ends a normalize even for a zero value
  a_r5_norm_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && mode_q == OP_NORM && cnt_q == NORM_LIMIT && !start_i) |=> !busy_o)
    else $error("a_r5_norm_limit");
endmodule

// File: rtl/shnorm_flags.sv
module shnorm_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic data_wr_i,
  input  logic last_rd_i,
  input  logic ctrl_rd_i,
  input  logic ovf_i,
  output logic err_o,
  output logic ovf_o
);
  logic pending_q, err_q, ovf_q;
  logic err_set;

  assign err_set = data_wr_i && pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      err_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (start_i)        pending_q <= 1'b1;
      else if (last_rd_i) pending_q <= 1'b0;
      if (err_set)        err_q <= 1'b1;
      else if (ctrl_rd_i) err_q <= 1'b0;
      if (ovf_i)          ovf_q <= 1'b1;
      else if (ctrl_rd_i) ovf_q <= 1'b0;
    end
  end

  assign err_o = err_q;
  assign ovf_o = ovf_q;

  a_r7_err_on_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && pending_q) |=> err_o)
    else $error("a_r7_err_on_retrigger");

  a_r8_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_rd_i && !start_i) |=> !pending_q)
    else $error("a_r8_rearm");

  a_r9_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_rd_i && !(data_wr_i && pending_q)) |=> !err_o)
    else $error("a_r9_err_clear");

  a_r10_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_o)
    else $error("a_r10_ovf_set");
endmodule

// File: rtl/shnorm_unit.sv
module shnorm_unit #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              ovf_flag_i,
  output logic              busy_o
);
  localparam int unsigned       NUM_BYTES = DATA_W / BYTE_W;
  localparam int unsigned       CNT_W     = $clog2(DATA_W);
  localparam int unsigned       DIR_BIT   = CNT_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_BYTES);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);

  logic                 in_data_range, data_wr, ctrl_wr, ctrl_rd, last_rd;
  logic [NUM_BYTES-1:0] byte_we;
  logic                 step_en, step_right, msb, busy, dir, err, ovf;
  logic [CNT_W-1:0]     cnt;
  logic [DATA_W-1:0]    data_w;
  logic [CNT_W+2:0]     ctrl_word;

  assign in_data_range = addr_i < CTRL_ADDR;
  assign data_wr       = wr_en_i && in_data_range;
  assign ctrl_wr       = wr_en_i && addr_i == CTRL_ADDR;
  assign ctrl_rd       = rd_en_i && addr_i == CTRL_ADDR;
  assign last_rd       = rd_en_i && addr_i == LAST_ADDR;

  // the shifter owns the data while busy
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte_we
    assign byte_we[b] = wr_en_i && !busy && addr_i == ADDR_W'(b);
  end

  shnorm_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_datapath (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_we_i    (byte_we),
    .wdata_i      (wdata_i),
    .step_en_i    (step_en),
    .step_right_i (step_right),
    .data_o       (data_w),
    .msb_o        (msb)
  );

  shnorm_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (ctrl_wr),
    .start_dir_i  (wdata_i[DIR_BIT]),
    .start_cnt_i  (wdata_i[CNT_W-1:0]),
    .msb_i        (msb),
    .busy_o       (busy),
    .step_en_o    (step_en),
    .step_right_o (step_right),
    .dir_o        (dir),
    .cnt_o        (cnt)
  );

  shnorm_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (ctrl_wr),
    .data_wr_i (data_wr),
    .last_rd_i (last_rd),
    .ctrl_rd_i (ctrl_rd),
    .ovf_i     (ovf_flag_i),
    .err_o     (err),
    .ovf_o     (ovf)
  );

  assign ctrl_word = {err, ovf, dir, cnt};

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) rdata_o = BYTE_W'(ctrl_word);
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (addr_i == ADDR_W'(b)) rdata_o = data_w[b*BYTE_W +: BYTE_W];
    end
  end

  assign busy_o = busy;

  // R11: a control write during an operation keeps the unit busy
  a_r11_restart_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && busy) |=> busy_o)
    else $error("a_r11_restart_busy");
endmodule

// File: tb/shnorm_unit_tb_top.sv
module shnorm_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // input word, control byte, expected result, expected count, expected busy cycles
  localparam logic [31:0] V_IN [NVEC] = '{32'h0000_00F1, 32'h8000_0001, 32'hF000_000F,
    32'hF000_000F, 32'h0000_1234, 32'h8000_0000, 32'h0000_0001, 32'h0000_0000,
    32'h1234_5678, 32'h0001_0000};
  localparam logic [7:0] V_CTRL [NVEC] = '{8'h04, 8'h21, 8'h3F, 8'h1F, 8'h00, 8'h00,
    8'h20, 8'h00, 8'h28, 8'h10};
  localparam logic [31:0] V_OUT [NVEC] = '{32'h0000_0F10, 32'h4000_0000, 32'h0000_0001,
    32'h8000_0000, 32'h91A0_0000, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000,
    32'h0012_3456, 32'h0000_0000};
  localparam logic [4:0] V_CNT [NVEC] = '{5'd4, 5'd1, 5'd31, 5'd31, 5'd19, 5'd0, 5'd31,
    5'd31, 5'd8, 5'd16};
  localparam int V_CYC [NVEC] = '{4, 1, 31, 31, 20, 1, 32, 32, 8, 16};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ovf_in = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy;

  int  n_tests = 0, n_fail = 0;
  bit  done = 1'b0;

  shnorm_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .ovf_flag_i(ovf_in), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge
  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic load_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) bus_write(3'(b), w[b*8 +: 8]);
  endtask

  task automatic read_word(output logic [31:0] w);
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin
      bus_read(3'(b), d);
      w[b*8 +: 8] = d;
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  r;
    int          n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 busy", 32'(busy), 32'd0);
    bus_read(3'd4, r);
    check("R12 ctrl", 32'(r), 32'h00);
    read_word(w);
    check("R12 data", w, 32'h0);

    // R3 / R4 / R5 vector table
    for (int i = 0; i < NVEC; i++) begin
      load_word(V_IN[i]);
      bus_write(3'd4, V_CTRL[i]);
      check("R2 busy after write", 32'(busy), 32'd1);
      wait_idle(n);
      check("R3/R4 busy cycles", 32'(n), 32'(V_CYC[i]));
      read_word(w);
      check("R3/R4/R5 result", w, V_OUT[i]);
      bus_read(3'd4, r);
      check("R1/R8 ctrl readback", 32'(r), 32'({2'b00, V_CTRL[i][5], V_CNT[i]}));
    end

    // R1 flag bits in a control write are ignored; unmapped addresses read 0
    load_word(32'h0000_0001);
    bus_write(3'd4, 8'hC2);
    wait_idle(n);
    read_word(w);
    check("R1 shift with flag bits", w, 32'h0000_0004);
    bus_read(3'd4, r);
    check("R1 flag bits ignored", 32'(r), 32'h02);
    bus_read(3'd5, r);
    check("R1 addr 5 reads 0", 32'(r), 32'h00);
    bus_read(3'd7, r);
    check("R1 addr 7 reads 0", 32'(r), 32'h00);

    // R7 / R9 / R8 retrigger error
    load_word(32'h0000_0003);
    bus_write(3'd4, 8'h01);
    wait_idle(n);
    bus_write(3'd0, 8'h55);
    bus_read(3'd4, r);
    check("R7 err set", 32'(r), 32'h81);
    bus_read(3'd4, r);
    check("R9 err cleared", 32'(r), 32'h01);
    bus_read(3'd3, r);
    bus_write(3'd0, 8'h77);
    bus_read(3'd4, r);
    check("R8 no err after addr 3 read", 32'(r), 32'h01);

    // R6 write during busy ignored
    load_word(32'h0000_00FF);
    bus_write(3'd4, 8'h08);
    bus_write(3'd0, 8'hAA);
    wait_idle(n);
    read_word(w);
    check("R6 data unchanged by busy write", w, 32'h0000_FF00);
    bus_read(3'd4, r);
    check("R7 err from busy write", 32'(r), 32'h88);
    bus_read(3'd4, r);

    // R11 restart mid-operation
    load_word(32'h0000_00FF);
    bus_write(3'd4, 8'h08);
    @(negedge clk);
    bus_write(3'd4, 8'h24);
    check("R11 busy after restart", 32'(busy), 32'd1);
    wait_idle(n);
    check("R11 restart cycles", 32'(n), 32'd4);
    read_word(w);
    check("R11 restart result", w, 32'h0000_001F);
    bus_read(3'd4, r);
    check("R11 restart ctrl", 32'(r), 32'h24);

    // R10 overflow flag
    ovf_in = 1'b1;
    @(negedge clk);
    ovf_in = 1'b0;
    bus_read(3'd4, r);
    check("R10 ovf set", 32'(r[6]), 32'd1);
    bus_read(3'd4, r);
    check("R10 ovf cleared", 32'(r[6]), 32'd0);
    ovf_in = 1'b1;
    bus_read(3'd4, r);
    ovf_in = 1'b0;
    bus_read(3'd4, r);
    check("R10 set wins over clear", 32'(r[6]), 32'd1);
    bus_read(3'd4, r);
    check("R10 ovf cleared again", 32'(r[6]), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule